// File: doc/BRIEF.md
# Video Port Byte-Access Adapter

This block sits between a banked 8-bit coprocessor window and the 16-bit ports of a video controller. It takes one byte read or byte write strobe at a time, with the low eight address bits and a data byte. It turns each access into a single-cycle request on the matching 16-bit port: data, control, horizontal/vertical counter or test register. It also serves a write-only sound generator port in the same window.

Reads split each 16-bit port word into a high and a low byte according to the address. The high byte of the control word comes back with its upper six bits forced to ones. Writes copy the byte into both halves of the 16-bit payload. Reads and writes decode the address with different masks. Accesses that hit no port are classified as unused, which is harmless, or as lockup. A lockup freezes the adapter until reset, because the requesting processor would hang on such an access.

The controller has three states. ST_IDLE accepts strobes. ST_FETCH lasts one cycle and captures the port response of an outstanding read. ST_HALT is entered after a lockup and left only by reset. The transitions are:
- ST_IDLE to ST_FETCH on any read.
- ST_IDLE to ST_HALT on a lockup write.
- ST_IDLE to ST_IDLE on any other write, or when there is no strobe.
- ST_FETCH to ST_HALT when the captured read was a lockup.
- ST_FETCH to ST_IDLE otherwise.
- ST_HALT to ST_HALT always.

Top module: `vid_byte_port`

## Requirements
- R1: After reset every pulse output, `bus_rvalid` and `hung` are low.
- R2: A read whose address ANDed with 0xFD gives 0x00 returns bits 15:8 of the data-port response. A read that gives 0x01 returns bits 7:0. Either read pulses `vid_data_rd`.
- R3: A read that decodes (mask 0xFD) to 0x04 returns 0xFC ORed with bits 9:8 of the control response. A read that decodes to 0x05 returns bits 7:0 of the control response. Either read pulses `vid_ctrl_rd`.
- R4: A read that decodes (mask 0xFD) to 0x08 or 0x0C returns bits 15:8 of the H/V counter response. A read that decodes to 0x09 or 0x0D returns bits 7:0. Either read pulses `vid_hv_rd`.
- R5: A read that decodes (mask 0xFD) to 0x18, 0x19, 0x1C or 0x1D pulses `acc_unused`, makes no port request and returns 0xFF.
- R6: A read that decodes to any other value pulses `acc_lockup`, makes no port request, returns 0xFF and then raises `hung`.
- R7: A write that decodes (mask 0xFC) to 0x00, 0x04 or 0x1C pulses `vid_data_wr`, `vid_ctrl_wr` or `vid_test_wr` respectively. The payload `vid_wdata` is the byte in both halves.
- R8: A write that decodes (mask 0xFC) to 0x10 or 0x14 pulses `snd_wr` with the byte when address bit 0 is 1. When bit 0 is 0 it pulses only `acc_unused`.
- R9: A write that decodes to 0x18 pulses only `acc_unused`. A write that decodes to any value not named in R7 or R8 pulses `acc_lockup` and raises `hung` in the same cycle.
- R10: A port request or classification pulse appears in the cycle after the strobe edge. Read data is captured from the response one cycle later and shown with a one-cycle `bus_rvalid`. At most one request or classification pulse is high at a time.
- R11: A strobe that arrives in the cycle after a read strobe (ST_FETCH) is ignored.
- R12: Once `hung` is high it stays high and all strobes are ignored until reset. Reset clears it.
- R13: When read and write strobes are high together, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Byte read strobe, one cycle |
| bus_wr | input | 1 | Byte write strobe, one cycle |
| bus_addr | input | 8 | Low address bits of the window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid pulse |
| vid_data_rd | output | 1 | Data port read request |
| vid_ctrl_rd | output | 1 | Control port read request |
| vid_hv_rd | output | 1 | H/V counter read request |
| vid_data_wr | output | 1 | Data port write request |
| vid_ctrl_wr | output | 1 | Control port write request |
| vid_test_wr | output | 1 | Test register write request |
| vid_wdata | output | 16 | Write payload, byte duplicated |
| vid_data_rsp | input | 16 | Data port response word |
| vid_ctrl_rsp | input | 16 | Control/status response word |
| vid_hv_rsp | input | 16 | H/V counter response word |
| snd_wr | output | 1 | Sound generator write pulse |
| snd_data | output | 8 | Sound generator byte |
| acc_unused | output | 1 | Unused-access pulse |
| acc_lockup | output | 1 | Lockup-access pulse |
| hung | output | 1 | Adapter frozen after lockup |

## Verification
Reads are issued at addresses with bit 1 set and with bit 1 clear. This separates the read mask from the write mask and proves the H/V aliases. The control response has bits 9:8 different from its upper bits, so the pad cannot be confused with raw data. Writes use odd and even addresses and bit 1 set, which shows the sound-port parity rule and the wider write mask. Collisions (write during ST_FETCH, both strobes together) and both lockup paths, followed by a fresh reset, show that the priority, busy and freeze behaviour differ from plain idle decoding.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
    typedef enum logic [2:0] {
        RS_DATA_HI, RS_DATA_LO, RS_CTRL_HI, RS_CTRL_LO,
        RS_HV_HI, RS_HV_LO, RS_UNUSED, RS_LOCK
    } rd_sel_e;

    typedef enum logic [2:0] {
        WS_DATA, WS_CTRL, WS_TEST, WS_SOUND, WS_UNUSED, WS_LOCK
    } wr_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_FETCH, ST_HALT
    } fsm_st_e;

    localparam logic [7:0] RD_MASK = 8'hFD;
    localparam logic [7:0] WR_MASK = 8'hFC;
endpackage

// File: rtl/vpa_rd_decode.sv
module vpa_rd_decode
    import vpa_pkg::*;
(
    input  logic [7:0] addr,
    output rd_sel_e    sel
);
    logic [7:0] key;
    assign key = addr & RD_MASK;

    always_comb begin
        case (key)
            8'h00:                      sel = RS_DATA_HI;
            8'h01:                      sel = RS_DATA_LO;
            8'h04:                      sel = RS_CTRL_HI;
            8'h05:                      sel = RS_CTRL_LO;
            8'h08, 8'h0C:               sel = RS_HV_HI;
            8'h09, 8'h0D:               sel = RS_HV_LO;
            8'h18, 8'h19, 8'h1C, 8'h1D: sel = RS_UNUSED;
            default:                    sel = RS_LOCK;
        endcase
    end
endmodule

// File: rtl/vpa_wr_decode.sv
module vpa_wr_decode
    import vpa_pkg::*;
(
    input  logic [7:0] addr,
    output wr_sel_e    sel
);
    logic [7:0] key;
    assign key = addr & WR_MASK;

    always_comb begin
        case (key)
            8'h00:        sel = WS_DATA;
            8'h04:        sel = WS_CTRL;
            8'h1C:        sel = WS_TEST;
            8'h10, 8'h14: sel = addr[0] ? WS_SOUND : WS_UNUSED;
            8'h18:        sel = WS_UNUSED;
            default:      sel = WS_LOCK;
        endcase
    end
endmodule

// File: rtl/vpa_byte_pick.sv
module vpa_byte_pick
    import vpa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  rd_sel_e               sel,
    input  logic [2*BYTE_W-1:0]   data_rsp,
    input  logic [2*BYTE_W-1:0]   ctrl_rsp,
    input  logic [2*BYTE_W-1:0]   hv_rsp,
    output logic [BYTE_W-1:0]     pick
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD_W  = BYTE_W - 2;

    always_comb begin
        unique case (sel)
            RS_DATA_HI: pick = data_rsp[WORD_W-1:BYTE_W];
            RS_DATA_LO: pick = data_rsp[BYTE_W-1:0];
            RS_CTRL_HI: pick = {{PAD_W{1'b1}}, ctrl_rsp[BYTE_W+1:BYTE_W]};
            RS_CTRL_LO: pick = ctrl_rsp[BYTE_W-1:0];
            RS_HV_HI:   pick = hv_rsp[WORD_W-1:BYTE_W];
            RS_HV_LO:   pick = hv_rsp[BYTE_W-1:0];
            default:    pick = '1;
        endcase
    end
endmodule

// File: rtl/vpa_fsm.sv
module vpa_fsm
    import vpa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    input  rd_sel_e              rsel,
    input  wr_sel_e              wsel,
    input  logic [BYTE_W-1:0]    pick_byte,
    output rd_sel_e              rsel_q,
    output logic [BYTE_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    output logic                 vid_data_rd,
    output logic                 vid_ctrl_rd,
    output logic                 vid_hv_rd,
    output logic                 vid_data_wr,
    output logic                 vid_ctrl_wr,
    output logic                 vid_test_wr,
    output logic [2*BYTE_W-1:0]  vid_wdata,
    output logic                 snd_wr,
    output logic [BYTE_W-1:0]    snd_data,
    output logic                 acc_unused,
    output logic                 acc_lockup,
    output logic                 hung
);
    localparam int WORD_W = 2 * BYTE_W;

    fsm_st_e state, state_nx;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (bus_rd)                        state_nx = ST_FETCH;
                else if (bus_wr && wsel == WS_LOCK) state_nx = ST_HALT;
            end
            ST_FETCH: state_nx = (rsel_q == RS_LOCK) ? ST_HALT : ST_IDLE;
            ST_HALT:  state_nx = ST_HALT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsel_q      <= RS_UNUSED;
            bus_rdata   <= '0;
            bus_rvalid  <= 1'b0;
            vid_data_rd <= 1'b0;
            vid_ctrl_rd <= 1'b0;
            vid_hv_rd   <= 1'b0;
            vid_data_wr <= 1'b0;
            vid_ctrl_wr <= 1'b0;
            vid_test_wr <= 1'b0;
            vid_wdata   <= '0;
            snd_wr      <= 1'b0;
            snd_data    <= '0;
            acc_unused  <= 1'b0;
            acc_lockup  <= 1'b0;
        end else begin
            bus_rvalid  <= 1'b0;
            vid_data_rd <= 1'b0;
            vid_ctrl_rd <= 1'b0;
            vid_hv_rd   <= 1'b0;
            vid_data_wr <= 1'b0;
            vid_ctrl_wr <= 1'b0;
            vid_test_wr <= 1'b0;
            snd_wr      <= 1'b0;
            acc_unused  <= 1'b0;
            acc_lockup  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (bus_rd) begin
                        rsel_q      <= rsel;
                        vid_data_rd <= (rsel == RS_DATA_HI) || (rsel == RS_DATA_LO);
                        vid_ctrl_rd <= (rsel == RS_CTRL_HI) || (rsel == RS_CTRL_LO);
                        vid_hv_rd   <= (rsel == RS_HV_HI)   || (rsel == RS_HV_LO);
                        acc_unused  <= (rsel == RS_UNUSED);
                        acc_lockup  <= (rsel == RS_LOCK);
                    end else if (bus_wr) begin
                        vid_wdata   <= {bus_wdata, bus_wdata};
                        snd_data    <= bus_wdata;
                        vid_data_wr <= (wsel == WS_DATA);
                        vid_ctrl_wr <= (wsel == WS_CTRL);
                        vid_test_wr <= (wsel == WS_TEST);
                        snd_wr      <= (wsel == WS_SOUND);
                        acc_unused  <= (wsel == WS_UNUSED);
                        acc_lockup  <= (wsel == WS_LOCK);
                    end
                end
                ST_FETCH: begin
                    bus_rvalid <= 1'b1;
                    bus_rdata  <= pick_byte;
                end
                ST_HALT: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign hung = (state == ST_HALT);

    logic any_rd_req, any_wr_req;
    assign any_rd_req = vid_data_rd | vid_ctrl_rd | vid_hv_rd;
    assign any_wr_req = vid_data_wr | vid_ctrl_wr | vid_test_wr | snd_wr;

    // R10: a port read request is followed by read data in the next cycle
    a_r10_rd_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd_req |=> bus_rvalid);

    // R10: requests and classifications are mutually exclusive
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_data_rd, vid_ctrl_rd, vid_hv_rd, vid_data_wr, vid_ctrl_wr,
                  vid_test_wr, snd_wr, acc_unused, acc_lockup}));

    // R7: payload carries the same byte in both halves
    a_r7_word_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_data_wr | vid_ctrl_wr | vid_test_wr) |->
            vid_wdata[WORD_W-1:BYTE_W] == vid_wdata[BYTE_W-1:0]);

    // R11: nothing new is launched out of the fetch cycle
    a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> !(any_rd_req | any_wr_req | acc_unused | acc_lockup));

    // R12: the frozen condition never clears without reset
    a_r12_hung_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hung |=> hung);

    // R12: while frozen, no outputs pulse
    a_r12_hung_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hung && $past(hung)) |-> !(bus_rvalid | any_rd_req | any_wr_req |
                                    acc_unused | acc_lockup));
endmodule

// File: rtl/vid_byte_port.sv
module vid_byte_port
    import vpa_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              vid_data_rd,
    output logic              vid_ctrl_rd,
    output logic              vid_hv_rd,
    output logic              vid_data_wr,
    output logic              vid_ctrl_wr,
    output logic              vid_test_wr,
    output logic [WORD_W-1:0] vid_wdata,
    input  logic [WORD_W-1:0] vid_data_rsp,
    input  logic [WORD_W-1:0] vid_ctrl_rsp,
    input  logic [WORD_W-1:0] vid_hv_rsp,
    output logic              snd_wr,
    output logic [BYTE_W-1:0] snd_data,
    output logic              acc_unused,
    output logic              acc_lockup,
    output logic              hung
);
    rd_sel_e           rsel, rsel_q;
    wr_sel_e           wsel;
    logic [BYTE_W-1:0] pick_byte;

    vpa_rd_decode u_rdec (.addr(bus_addr), .sel(rsel));
    vpa_wr_decode u_wdec (.addr(bus_addr), .sel(wsel));

    vpa_byte_pick #(.BYTE_W(BYTE_W)) u_pick (
        .sel      (rsel_q),
        .data_rsp (vid_data_rsp),
        .ctrl_rsp (vid_ctrl_rsp),
        .hv_rsp   (vid_hv_rsp),
        .pick     (pick_byte)
    );

    vpa_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .rsel        (rsel),
        .wsel        (wsel),
        .pick_byte   (pick_byte),
        .rsel_q      (rsel_q),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid),
        .vid_data_rd (vid_data_rd),
        .vid_ctrl_rd (vid_ctrl_rd),
        .vid_hv_rd   (vid_hv_rd),
        .vid_data_wr (vid_data_wr),
        .vid_ctrl_wr (vid_ctrl_wr),
        .vid_test_wr (vid_test_wr),
        .vid_wdata   (vid_wdata),
        .snd_wr      (snd_wr),
        .snd_data    (snd_data),
        .acc_unused  (acc_unused),
        .acc_lockup  (acc_lockup),
        .hung        (hung)
    );
endmodule

// File: tb/sim_vid_byte_port.sv
`timescale 1ns/1ps
module sim_vid_byte_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata, snd_data;
    logic        bus_rvalid, vid_data_rd, vid_ctrl_rd, vid_hv_rd;
    logic        vid_data_wr, vid_ctrl_wr, vid_test_wr, snd_wr;
    logic        acc_unused, acc_lockup, hung;
    logic [15:0] vid_wdata;
    logic [15:0] vid_data_rsp = 16'hA55A;
    logic [15:0] vid_ctrl_rsp = 16'h5134;
    logic [15:0] vid_hv_rsp   = 16'h7E81;

    always #2 clk = ~clk;

    vid_byte_port u0 (.*);

    int total = 0, bad = 0;
    string tag = "R1";
    bit started = 0, done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int   m_st = 0;
    int   m_key = 0;
    bit   m_lock = 0;
    logic [10:0] e_vec = '0;  // drd,crd,hrd,dwr,cwr,twr,swr,unu,lck,rv,hung
    logic [7:0]  e_rd = '0, e_byte = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; e_vec = '0;
        end else begin
            e_vec = '0;
            case (m_st)
                0: if (bus_rd) begin
                        m_key = int'(bus_addr & 8'hFD);
                        m_lock = 0;
                        if (m_key == 0 || m_key == 1) e_vec[10] = 1;
                        else if (m_key == 4 || m_key == 5) e_vec[9] = 1;
                        else if (m_key == 8 || m_key == 9 || m_key == 12 || m_key == 13) e_vec[8] = 1;
                        else if (m_key == 24 || m_key == 25 || m_key == 28 || m_key == 29) e_vec[3] = 1;
                        else begin e_vec[2] = 1; m_lock = 1; end
                        m_st = 1;
                    end else if (bus_wr) begin
                        int k;
                        k = int'(bus_addr & 8'hFC);
                        e_byte = bus_wdata;
                        if (k == 0) e_vec[7] = 1;
                        else if (k == 4) e_vec[6] = 1;
                        else if (k == 28) e_vec[5] = 1;
                        else if (k == 16 || k == 20) begin
                            if (bus_addr[0]) e_vec[4] = 1; else e_vec[3] = 1;
                        end else if (k == 24) e_vec[3] = 1;
                        else begin e_vec[2] = 1; m_st = 2; end
                    end
                1: begin
                    e_vec[1] = 1;
                    case (m_key)
                        0: e_rd = vid_data_rsp[15:8];
                        1: e_rd = vid_data_rsp[7:0];
                        4: e_rd = 8'hFC | {6'd0, vid_ctrl_rsp[9:8]};
                        5: e_rd = vid_ctrl_rsp[7:0];
                        8, 12: e_rd = vid_hv_rsp[15:8];
                        9, 13: e_rd = vid_hv_rsp[7:0];
                        default: e_rd = 8'hFF;
                    endcase
                    m_st = m_lock ? 2 : 0;
                end
                default: ;
            endcase
            e_vec[0] = (m_st == 2);
        end
        started = 1;
    end

    // per-cycle comparison and result capture, away from the active edge
    logic [10:0] d_vec;
    assign d_vec = {vid_data_rd, vid_ctrl_rd, vid_hv_rd, vid_data_wr, vid_ctrl_wr,
                    vid_test_wr, snd_wr, acc_unused, acc_lockup, bus_rvalid, hung};
    logic [10:0] seen = '0;
    logic [7:0]  last_rd = '0, last_snd = '0;
    logic [15:0] last_w = '0;
    bit          got_rv = 0;

    always @(negedge clk) begin
        if (started) begin
            chk(d_vec == e_vec, {tag, "/R10 pulses"}, int'(d_vec), int'(e_vec));
            if (bus_rvalid && e_vec[1]) chk(bus_rdata == e_rd, {tag, " rdata"}, int'(bus_rdata), int'(e_rd));
            if (|e_vec[7:5]) chk(vid_wdata == {e_byte, e_byte}, {tag, " wdata"}, int'(vid_wdata), int'({e_byte, e_byte}));
            if (e_vec[4]) chk(snd_data == e_byte, {tag, " snd"}, int'(snd_data), int'(e_byte));
        end
        if (rst_n) begin
            seen <= seen | d_vec;
            if (bus_rvalid) begin last_rd <= bus_rdata; got_rv <= 1; end
            if (vid_data_wr | vid_ctrl_wr | vid_test_wr) last_w <= vid_wdata;
            if (snd_wr) last_snd <= snd_data;
        end
    end

    task automatic clr();
        @(posedge clk); seen = '0; got_rv = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        clr();
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        clr();
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(d_vec == 11'd0, "R1 reset outputs", int'(d_vec), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(d_vec == 11'd0, "R1 idle after reset", int'(d_vec), 0);

        tag = "R2";
        rd(8'h00); chk(got_rv && last_rd == 8'hA5, "R2 data hi", int'(last_rd), 'hA5);
        chk(seen[10], "R2 data read request", int'(seen), 'h400);
        rd(8'h03); chk(last_rd == 8'h5A, "R2 data lo via mask", int'(last_rd), 'h5A);

        tag = "R3";
        rd(8'h04); chk(last_rd == 8'hFD, "R3 ctrl hi pad", int'(last_rd), 'hFD);
        rd(8'h07); chk(last_rd == 8'h34, "R3 ctrl lo", int'(last_rd), 'h34);

        tag = "R4";
        rd(8'h0C); chk(last_rd == 8'h7E, "R4 hv hi alias", int'(last_rd), 'h7E);
        rd(8'h09); chk(last_rd == 8'h81, "R4 hv lo", int'(last_rd), 'h81);
        rd(8'h0F); chk(last_rd == 8'h81, "R4 hv lo alias", int'(last_rd), 'h81);

        tag = "R5";
        rd(8'h1F); chk(last_rd == 8'hFF && seen[10:4] == 0 && seen[3], "R5 unused read", int'(seen), 'h2);

        tag = "R7";
        wr(8'h02, 8'h3C); chk(seen[7] && last_w == 16'h3C3C, "R7 data write", int'(last_w), 'h3C3C);
        wr(8'h05, 8'hC3); chk(seen[6] && last_w == 16'hC3C3, "R7 ctrl write", int'(last_w), 'hC3C3);
        wr(8'h1E, 8'h11); chk(seen[5] && last_w == 16'h1111, "R7 test write", int'(last_w), 'h1111);

        tag = "R8";
        wr(8'h13, 8'h9A); chk(seen[4] && last_snd == 8'h9A, "R8 sound odd", int'(last_snd), 'h9A);
        wr(8'h16, 8'h55); chk(seen[10:4] == 0 && seen[3], "R8 sound even ignored", int'(seen), 'h8);

        tag = "R9";
        wr(8'h1A, 8'h77); chk(seen[10:4] == 0 && seen[3] && !hung, "R9 unused write", int'(seen), 'h8);

        tag = "R11";
        clr();
        @(negedge clk); bus_rd = 1; bus_addr = 8'h00;
        @(negedge clk); bus_rd = 0; bus_wr = 1; bus_wdata = 8'hEE;
        @(negedge clk); bus_wr = 0;
        repeat (2) @(negedge clk);
        chk(!seen[7] && got_rv, "R11 write during fetch ignored", int'(seen), 'h402);

        tag = "R13";
        clr();
        @(negedge clk); bus_rd = 1; bus_wr = 1; bus_addr = 8'h01; bus_wdata = 8'h44;
        @(negedge clk); bus_rd = 0; bus_wr = 0;
        repeat (3) @(negedge clk);
        chk(!seen[7] && got_rv && last_rd == 8'h5A, "R13 read wins", int'(last_rd), 'h5A);

        tag = "R6";
        rd(8'h10); chk(last_rd == 8'hFF && seen[2] && hung, "R6 lockup read", int'(hung), 1);

        tag = "R12";
        rd(8'h00); chk(seen[10:2] == 0 && !got_rv && hung, "R12 frozen ignores read", int'(seen), 1);
        wr(8'h00, 8'h12); chk(seen[10:2] == 0 && hung, "R12 frozen ignores write", int'(seen), 1);
        do_reset(); chk(!hung, "R12 reset clears hung", int'(hung), 0);

        tag = "R9";
        wr(8'h20, 8'h01); chk(seen[2] && hung, "R9 lockup write", int'(hung), 1);
        do_reset();

        tag = "R10";
        rd(8'h01); chk(got_rv && last_rd == 8'h5A, "R10 read after re-reset", int'(last_rd), 'h5A);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule